// File: doc/BRIEF.md
# Periodic Request Queue with Frame-Parity Gating

This block holds the periodic IN requests (isochronous or interrupt) of a USB host scheduler. Each time the configuration side writes a channel-enable, one entry is pushed. The entry carries a channel number, an odd-frame flag, a packets-per-frame count and a marker that turns it into a channel-disable command. Disable commands use up slots just as requests do.

A start-of-frame strobe comes with the current 11-bit frame number. Bit 0 of that number is the frame parity. The head entry is offered to the token generator only while its odd-frame flag equals the parity. A high-bandwidth entry stays at the head until as many tokens as its count asks for have been accepted within one frame. A disable entry at the head leaves the queue on the next frame boundary and raises a one-cycle halted pulse that carries its channel number.

The depth is a parameter. Four slots are enough for two ordinary periodic endpoints. Eight slots are needed once a high-bandwidth endpoint is in use.

Top module: `periodic_req_queue`

## Requirements
- R1: A push with `push_valid` high while `full` is low stores exactly one entry. `full` is high exactly when DEPTH entries are held.
- R2: A push while `full` is high is dropped and leaves the stored entries unchanged. From the next cycle `overflow` is high, and it stays high until reset.
- R3: On a cycle with `sof_valid` high, bit 0 of `sof_frame` is stored as the parity (1 means an odd frame). `tok_valid` is high only if all of the following hold: a start-of-frame has been seen since reset, `sof_valid` is low, the queue is not empty, the head is not a disable entry, and the head's `push_odd` value equals the stored parity.
- R4: A head entry with count N (a count of 0 counts as 1) is popped when the N-th token accepted within the current frame completes (`tok_valid` and `tok_ready` both high). The accepted-token tally returns to zero on every start-of-frame.
- R5: A disable entry at the head is never offered as a token. On a cycle with `sof_valid` high it is popped. On the following cycle `halt_valid` is high for one cycle and `halt_ch` holds its channel.
- R6: Entries leave in push order. `tok_ch` shows the channel of the head entry.
- R7: After reset the queue is empty, and `full`, `overflow`, `tok_valid` and `halt_valid` are low.
- R8: A push and a pop in the same cycle, with `full` low, both take effect. The occupancy is then unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Channel-enable write; pushes one entry |
| push_ch | input | CH_W | Channel number of the entry |
| push_odd | input | 1 | 1: issue in an odd frame, 0: in an even frame |
| push_cnt | input | CNT_W | Packets expected per frame (0 treated as 1) |
| push_dis | input | 1 | Entry is a channel-disable command |
| full | output | 1 | Queue holds DEPTH entries |
| overflow | output | 1 | Sticky: a push was dropped |
| sof_valid | input | 1 | Start-of-frame strobe |
| sof_frame | input | FRAME_W | Frame number valid with the strobe |
| tok_valid | output | 1 | Head request offered to the token generator |
| tok_ch | output | CH_W | Channel of the offered request |
| tok_ready | input | 1 | Token generator accepts the offered request |
| halt_valid | output | 1 | One-cycle pulse: a disable entry was retired |
| halt_ch | output | CH_W | Channel of the retired disable entry |

## Verification
`tok_valid` and `tok_ch` follow the current inputs in the same cycle, because `sof_valid` masks them combinationally. The effects of a push, a pop and a parity change appear on the cycle after the clock edge that sees them. `full` and `overflow` are also due one cycle after the push, and the halted pulse one cycle after the start-of-frame that retires the entry. The bench drives every input on the falling edge and compares the outputs 1 ns later against a reference model. The model applies the same stimulus to its own state only after that comparison. Every expected value therefore belongs to the cycle whose edge comes next.

// File: rtl/periodic_req_queue.sv
module periodic_req_queue #(
  parameter int DEPTH   = 4,
  parameter int CH_W    = 4,
  parameter int CNT_W   = 2,
  parameter int FRAME_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push_valid,
  input  logic [CH_W-1:0]    push_ch,
  input  logic               push_odd,
  input  logic [CNT_W-1:0]   push_cnt,
  input  logic               push_dis,
  output logic               full,
  output logic               overflow,
  input  logic               sof_valid,
  input  logic [FRAME_W-1:0] sof_frame,
  output logic               tok_valid,
  output logic [CH_W-1:0]    tok_ch,
  input  logic               tok_ready,
  output logic               halt_valid,
  output logic [CH_W-1:0]    halt_ch
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST_SLOT = PW'(DEPTH - 1);

  logic [CH_W-1:0]  q_ch  [DEPTH];
  logic [CNT_W-1:0] q_cnt [DEPTH];
  logic [DEPTH-1:0] q_odd, q_dis;

  logic [PW-1:0]    rd_p, wr_p;
  logic [OW-1:0]    occ;
  logic             par, seen;
  logic [CNT_W-1:0] sent;

  logic             empty, head_dis, do_push, fire, last, dis_pop, pop;
  logic [CNT_W:0]   need;

  assign empty    = (occ == '0);
  assign full     = (occ == OW'(DEPTH));
  assign head_dis = q_dis[rd_p];
  assign tok_ch   = q_ch[rd_p];
  assign tok_valid = seen && !sof_valid && !empty && !head_dis && (q_odd[rd_p] == par);

  assign need    = (q_cnt[rd_p] == '0) ? (CNT_W+1)'(1) : {1'b0, q_cnt[rd_p]};
  assign do_push = push_valid && !full;
  assign fire    = tok_valid && tok_ready;
  assign last    = fire && (({1'b0, sent} + (CNT_W+1)'(1)) >= need);
  assign dis_pop = sof_valid && !empty && head_dis;
  assign pop     = last || dis_pop;

  always_ff @(posedge clk) begin
    if (do_push) begin
      q_ch[wr_p]  <= push_ch;
      q_cnt[wr_p] <= push_cnt;
      q_odd[wr_p] <= push_odd;
      q_dis[wr_p] <= push_dis;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_p       <= '0;
      wr_p       <= '0;
      occ        <= '0;
      par        <= 1'b0;
      seen       <= 1'b0;
      sent       <= '0;
      overflow   <= 1'b0;
      halt_valid <= 1'b0;
      halt_ch    <= '0;
    end else begin
      if (do_push) wr_p <= (wr_p == LAST_SLOT) ? '0 : wr_p + PW'(1);
      if (pop)     rd_p <= (rd_p == LAST_SLOT) ? '0 : rd_p + PW'(1);
      occ <= occ + OW'(do_push) - OW'(pop);
      if (push_valid && full) overflow <= 1'b1;
      if (sof_valid) begin
        par  <= sof_frame[0];
        seen <= 1'b1;
      end
      if (sof_valid || pop) sent <= '0;
      else if (fire)        sent <= sent + CNT_W'(1);
      halt_valid <= dis_pop;
      if (dis_pop) halt_ch <= q_ch[rd_p];
    end
  end

  a_r1_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OW'(DEPTH));
  a_r2_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  a_r3_quiet_on_sof: assert property (@(posedge clk) disable iff (!rst_n)
    sof_valid |-> !tok_valid);
  a_r5_halt_after_sof: assert property (@(posedge clk) disable iff (!rst_n)
    halt_valid |-> $past(sof_valid));
  a_r6_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && !tok_ready && !push_valid) |=> (sof_valid || (tok_valid && $stable(tok_ch))));
  a_r8_full_no_fire_grow: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);
endmodule

// File: tb/tb_periodic_req_queue.sv
module tb_periodic_req_queue;
  localparam int PERIOD = 10;
  localparam int D = 4;

  logic clk = 0, rst_n = 0;
  logic pv = 0, podd = 0, pdis = 0, sof = 0, rdy = 0;
  logic [3:0] pch = 0;
  logic [1:0] pcnt = 0;
  logic [10:0] frm = 0;
  logic full, overflow, tok_valid, halt_valid;
  logic [3:0] tok_ch, halt_ch;

  periodic_req_queue dut (
    .clk(clk), .rst_n(rst_n), .push_valid(pv), .push_ch(pch), .push_odd(podd),
    .push_cnt(pcnt), .push_dis(pdis), .full(full), .overflow(overflow),
    .sof_valid(sof), .sof_frame(frm), .tok_valid(tok_valid), .tok_ch(tok_ch),
    .tok_ready(rdy), .halt_valid(halt_valid), .halt_ch(halt_ch));

  always #(PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  int m_ch [D], m_cnt [D], m_odd [D], m_dis [D];
  int m_h = 0, m_n = 0, m_sent = 0, m_par = 0, m_seen = 0, m_ovf = 0;
  int m_halt = 0, m_haltch = 0, m_both = 0;

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_tok();
    return (m_seen && !sof && m_n > 0 && !m_dis[m_h] && m_odd[m_h] == m_par) ? 1 : 0;
  endfunction

  task automatic compare();
    int ev = exp_tok();
    chk(m_both ? "R8" : "R1", "full", int'(full), (m_n == D) ? 1 : 0);
    chk("R2", "overflow", int'(overflow), m_ovf);
    chk((m_n > 0 && m_cnt[m_h] > 1) ? "R4" : "R3", "tok_valid", int'(tok_valid), ev);
    if (ev) chk("R6", "tok_ch", int'(tok_ch), m_ch[m_h]);
    chk("R5", "halt_valid", int'(halt_valid), m_halt);
    if (m_halt) chk("R5", "halt_ch", int'(halt_ch), m_haltch);
  endtask

  task automatic model_step();
    int ev = exp_tok();
    int fire = ev && rdy;
    int need = (m_n > 0 && m_cnt[m_h] == 0) ? 1 : m_cnt[m_h];
    int last = fire && (m_sent + 1 >= need);
    int dpop = sof && m_n > 0 && m_dis[m_h];
    int pop = last || dpop;
    int push = pv && m_n < D;
    if (pv && m_n == D) m_ovf = 1;
    if (push) begin
      int t = (m_h + m_n) % D;
      m_ch[t] = pch; m_cnt[t] = pcnt; m_odd[t] = podd; m_dis[t] = pdis;
    end
    m_halt = dpop;
    if (dpop) m_haltch = m_ch[m_h];
    if (pop) m_h = (m_h + 1) % D;
    m_n = m_n + push - pop;
    m_both = push && pop;
    if (sof || pop) m_sent = 0;
    else if (fire) m_sent++;
    if (sof) begin m_par = frm[0]; m_seen = 1; end
  endtask

  task automatic step(int v, int ch, int odd, int cnt, int dis, int s, int f, int r);
    @(negedge clk);
    pv = v[0]; pch = ch[3:0]; podd = odd[0]; pcnt = cnt[1:0]; pdis = dis[0];
    sof = s[0]; frm = f[10:0]; rdy = r[0];
    #1;
    compare();
    model_step();
  endtask

  initial begin
    #(PERIOD * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R7", "full", int'(full), 0);
    chk("R7", "overflow", int'(overflow), 0);
    chk("R7", "tok_valid", int'(tok_valid), 0);
    chk("R7", "halt_valid", int'(halt_valid), 0);
    // R3: odd frame, then entries of both parities; R2: fifth push overflows
    step(0,0,0,0,0, 1,5, 0);
    step(1,1,1,1,0, 0,0, 0);
    step(1,2,0,1,0, 0,0, 0);
    step(1,3,1,3,0, 0,0, 0);
    step(1,4,0,0,1, 0,0, 0);
    step(1,9,1,1,0, 0,0, 0);
    step(0,0,0,0,0, 0,0, 1);
    step(0,0,0,0,0, 0,0, 1);
    step(0,0,0,0,0, 1,6, 1);
    step(0,0,0,0,0, 0,0, 1);
    step(0,0,0,0,0, 1,7, 1);
    // R4: three tokens for channel 3 in one odd frame
    for (int i = 0; i < 5; i++) step(0,0,0,0,0, 0,0, 1);
    // R5: disable entry retired on frame boundary
    step(0,0,0,0,0, 1,8, 1);
    step(0,0,0,0,0, 0,0, 1);
    step(0,0,0,0,0, 0,0, 1);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      step((r < 35) ? 1 : 0, $urandom_range(0,15), $urandom_range(0,1),
           $urandom_range(0,3), ($urandom_range(0,9) == 0) ? 1 : 0,
           ($urandom_range(0,7) == 0) ? 1 : 0, $urandom_range(0,2047),
           ($urandom_range(0,9) < 7) ? 1 : 0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule